// File: doc/BRIEF.md
# Down-Counting Interval Timer with Masked Interrupt

The block is a free-running 32-bit down counter kept as two 16-bit halves. Software starts and stops it through a control register. While it runs, the count drops by one on every cycle where the tick-enable input is high. The tick stands in for a fixed 5 MHz time base. When the count passes below zero, it reloads to all ones and raises a timer-complete flag in a status register.

The status register also collects event pulses from neighbouring logic. Software clears status bits by writing ones to them. A 15-bit mask selects which status bits may drive the single interrupt line. Access goes through a plain word-wide read/write port. Read data is registered and returned the cycle after the request.

Reading the low half of the count also captures the high half into a shadow. A later read of the high half then returns a value coherent with the low half already read.

Top module: `dtimer_top`

## Requirements
- R1: After reset the counter is stopped, the control register reads 0x0010 (stop bit 4 set, start bit 5 clear), both count halves read 0, and mask, status and `irq_o` are 0.
- R2: While running, each cycle with `tick_i` high lowers the 32-bit count by one; cycles without a tick leave it unchanged. Read data appears on `rdata_o` one cycle after `rd_en_i`. Addresses: 0 control, 1 count low, 2 count high, 3 mask, 4 status.
- R3: Writing control bit 5 (start) runs the counter and writing bit 4 (stop) freezes it. Each bit clears the other. If both are written in one cycle, start wins. A stopped counter ignores ticks.
- R4: A tick at count zero while running reloads the count to 0xFFFFFFFF and sets status bit 7 (timer complete).
- R5: A write to either count half replaces that half. In that cycle it takes priority over a tick, and counting then continues from the written value.
- R6: Mask writes drop bit 15, which always reads 0.
- R7: A status write clears exactly the set bits written as 1; bits written as 0 are kept.
- R8: When an event pulse and a clearing write hit the same status bit in one cycle, the bit ends up set.
- R9: After every clock edge, `irq_o` equals the OR of (mask AND status).
- R10: Reading the count low half captures the high half. Reading the high half returns the last captured value.
- R11: Each bit of `evt_i` sets the matching status bit. Status bit 15 can be set but never raises `irq_o`.
- R12: Reads of addresses 5 to 7 return 0, and writes there change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Count enable, one pulse per time-base period |
| evt_i | input | 16 | Status set pulses, one per bit |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Registered read data |
| irq_o | output | 1 | Interrupt request |

## Verification
The underflow reload is hard to reach from the ports, because a random 32-bit count would take billions of ticks to reach zero. The stimulus therefore writes the count halves with small values, mostly zero for the high half, so that running ticks cross zero often.

Collisions in a single cycle also need deliberate stimulus. These are a count write landing on a tick, and an event pulse landing on a clearing write to the same bit. Directed steps create each of them. The random phase then keeps producing them at random alongside reads of every address.

// File: rtl/dtimer_pkg.sv
package dtimer_pkg;
  localparam int unsigned ADDR_W    = 3;
  localparam int unsigned START_BIT = 5;
  localparam int unsigned STOP_BIT  = 4;
  localparam int unsigned TC_BIT    = 7;

  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd1;
  localparam logic [ADDR_W-1:0] A_CNT_HI = 3'd2;
  localparam logic [ADDR_W-1:0] A_MASK   = 3'd3;
  localparam logic [ADDR_W-1:0] A_STAT   = 3'd4;

  typedef struct packed {
    logic ctrl;
    logic lo;
    logic hi;
    logic mask;
    logic stat;
  } wr_strobe_t;
endpackage

// File: rtl/dtimer_count.sv
module dtimer_count #(
  parameter int unsigned HALF_W = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  tick_i,
  input  logic                  start_i,
  input  logic                  stop_i,
  input  logic                  wr_lo_i,
  input  logic                  wr_hi_i,
  input  logic [HALF_W-1:0]     wdata_i,
  output logic [2*HALF_W-1:0]   cnt_o,
  output logic                  run_o,
  output logic                  uflow_o
);
  localparam int unsigned CNT_W = 2 * HALF_W;

  logic [CNT_W-1:0] cnt_q;
  logic             run_q;
  logic             wr_any;
  logic             at_zero;

  assign wr_any  = wr_lo_i | wr_hi_i;
  assign at_zero = (cnt_q == '0);
  assign uflow_o = run_q & tick_i & at_zero & ~wr_any;
  assign cnt_o   = cnt_q;
  assign run_o   = run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
    end else if (start_i) begin
      run_q <= 1'b1;
    end else if (stop_i) begin
      run_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (wr_any) begin
      if (wr_lo_i) cnt_q[HALF_W-1:0]     <= wdata_i;
      if (wr_hi_i) cnt_q[CNT_W-1:HALF_W] <= wdata_i;
    end else if (run_q && tick_i) begin
      cnt_q <= at_zero ? {CNT_W{1'b1}} : cnt_q - CNT_W'(1);
    end
  end

  // R3: frozen without run or write
  p_hold_stopped_r3: assert property (@(posedge clk) disable iff (rst)
    (!run_q && !wr_any) |=> $stable(cnt_q));
  // R2: one step down per tick
  p_step_down_r2: assert property (@(posedge clk) disable iff (rst)
    (run_q && tick_i && !at_zero && !wr_any) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
  // R4: reload to all ones
  p_reload_r4: assert property (@(posedge clk) disable iff (rst)
    (run_q && tick_i && at_zero && !wr_any) |=> (cnt_q == {CNT_W{1'b1}}));
  // R3: start dominates stop
  p_start_wins_r3: assert property (@(posedge clk) disable iff (rst)
    start_i |=> run_q);
endmodule

// File: rtl/dtimer_irq.sv
module dtimer_irq #(
  parameter int unsigned STAT_W = 16,
  parameter int unsigned MASK_W = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_mask_i,
  input  logic              wr_stat_i,
  input  logic [STAT_W-1:0] wdata_i,
  input  logic [STAT_W-1:0] set_i,
  output logic [STAT_W-1:0] mask_o,
  output logic [STAT_W-1:0] stat_o,
  output logic              irq_o
);
  logic [MASK_W-1:0] mask_q, mask_d;
  logic [STAT_W-1:0] stat_q, stat_d, clr;
  logic [STAT_W-1:0] mask_ext_d, mask_ext_q;
  logic              irq_q;

  generate
    if (STAT_W > MASK_W) begin : g_pad
      assign mask_ext_d = {{(STAT_W-MASK_W){1'b0}}, mask_d};
      assign mask_ext_q = {{(STAT_W-MASK_W){1'b0}}, mask_q};
    end else begin : g_full
      assign mask_ext_d = mask_d[STAT_W-1:0];
      assign mask_ext_q = mask_q[STAT_W-1:0];
    end
  endgenerate

  always_comb begin
    mask_d = wr_mask_i ? wdata_i[MASK_W-1:0] : mask_q;
    clr    = wr_stat_i ? (wdata_i & stat_q) : '0;
    stat_d = (stat_q & ~clr) | set_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      stat_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      mask_q <= mask_d;
      stat_q <= stat_d;
      irq_q  <= |(mask_ext_d & stat_d);
    end
  end

  assign mask_o = mask_ext_q;
  assign stat_o = stat_q;
  assign irq_o  = irq_q;

  // R8: a pulse always lands
  p_set_wins_r8: assert property (@(posedge clk) disable iff (rst)
    (|set_i) |=> ((stat_q & $past(set_i)) == $past(set_i)));
  // R7: write-one-to-clear without pulses
  p_w1c_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_stat_i && set_i == '0) |=> (stat_q == ($past(stat_q) & ~$past(wdata_i))));
  // R9: line tracks masked status
  p_irq_track_r9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_q == |(mask_ext_q & stat_q)));
endmodule

// File: rtl/dtimer_regif.sv
module dtimer_regif
  import dtimer_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en_i,
  input  logic                rd_en_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [2*DATA_W-1:0] cnt_i,
  input  logic                run_i,
  input  logic [DATA_W-1:0]   mask_i,
  input  logic [DATA_W-1:0]   stat_i,
  output wr_strobe_t          wr_o,
  output logic [DATA_W-1:0]   rdata_o
);
  logic [DATA_W-1:0] shadow_q;
  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] ctrl_val;

  always_comb begin
    wr_o      = '0;
    if (wr_en_i) begin
      case (addr_i)
        A_CTRL:   wr_o.ctrl = 1'b1;
        A_CNT_LO: wr_o.lo   = 1'b1;
        A_CNT_HI: wr_o.hi   = 1'b1;
        A_MASK:   wr_o.mask = 1'b1;
        A_STAT:   wr_o.stat = 1'b1;
        default:  wr_o      = '0;
      endcase
    end
  end

  always_comb begin
    ctrl_val            = '0;
    ctrl_val[START_BIT] = run_i;
    ctrl_val[STOP_BIT]  = ~run_i;
    case (addr_i)
      A_CTRL:   rd_mux = ctrl_val;
      A_CNT_LO: rd_mux = cnt_i[DATA_W-1:0];
      A_CNT_HI: rd_mux = shadow_q;
      A_MASK:   rd_mux = mask_i;
      A_STAT:   rd_mux = stat_i;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q  <= '0;
      shadow_q <= '0;
    end else if (rd_en_i) begin
      rdata_q <= rd_mux;
      if (addr_i == A_CNT_LO) shadow_q <= cnt_i[2*DATA_W-1:DATA_W];
    end
  end

  assign rdata_o = rdata_q;

  // R10: low read captures high half
  p_capture_r10: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && addr_i == A_CNT_LO) |=> (shadow_q == $past(cnt_i[2*DATA_W-1:DATA_W])));
  // R10: high read returns the capture
  p_read_hi_r10: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && addr_i == A_CNT_HI) |=> (rdata_q == $past(shadow_q)));
  // R12: holes read zero
  p_hole_zero_r12: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && addr_i > A_STAT) |=> (rdata_q == '0));
endmodule

// File: rtl/dtimer_top.sv
module dtimer_top
  import dtimer_pkg::*;
#(
  parameter int unsigned HALF_W = 16,
  parameter int unsigned MASK_W = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic [HALF_W-1:0] evt_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [HALF_W-1:0] wdata_i,
  output logic [HALF_W-1:0] rdata_o,
  output logic              irq_o
);
  localparam int unsigned CNT_W = 2 * HALF_W;

  wr_strobe_t        wr;
  logic [CNT_W-1:0]  cnt;
  logic              run;
  logic              uflow;
  logic [HALF_W-1:0] set_vec;
  logic [HALF_W-1:0] mask;
  logic [HALF_W-1:0] stat;

  always_comb begin
    set_vec         = evt_i;
    set_vec[TC_BIT] = evt_i[TC_BIT] | uflow;
  end

  dtimer_regif #(.DATA_W(HALF_W)) u_regif (
    .clk     (clk),
    .rst     (rst),
    .wr_en_i (wr_en_i),
    .rd_en_i (rd_en_i),
    .addr_i  (addr_i),
    .cnt_i   (cnt),
    .run_i   (run),
    .mask_i  (mask),
    .stat_i  (stat),
    .wr_o    (wr),
    .rdata_o (rdata_o)
  );

  dtimer_count #(.HALF_W(HALF_W)) u_count (
    .clk     (clk),
    .rst     (rst),
    .tick_i  (tick_i),
    .start_i (wr.ctrl & wdata_i[START_BIT]),
    .stop_i  (wr.ctrl & wdata_i[STOP_BIT]),
    .wr_lo_i (wr.lo),
    .wr_hi_i (wr.hi),
    .wdata_i (wdata_i),
    .cnt_o   (cnt),
    .run_o   (run),
    .uflow_o (uflow)
  );

  dtimer_irq #(.STAT_W(HALF_W), .MASK_W(MASK_W)) u_irq (
    .clk       (clk),
    .rst       (rst),
    .wr_mask_i (wr.mask),
    .wr_stat_i (wr.stat),
    .wdata_i   (wdata_i),
    .set_i     (set_vec),
    .mask_o    (mask),
    .stat_o    (stat),
    .irq_o     (irq_o)
  );

  // R4: underflow raises timer-complete
  p_uflow_flag_r4: assert property (@(posedge clk) disable iff (rst)
    uflow |=> stat[TC_BIT]);
  // R11: top status bit never interrupts alone
  p_top_bit_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    (stat == {1'b1, {(HALF_W-1){1'b0}}}) |-> !irq_o);
endmodule

// File: tb/test_dtimer_top.sv
module test_dtimer_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_i = 1'b0;
  logic [15:0] evt_i = '0;
  logic        wr_en_i = 1'b0;
  logic        rd_en_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state
  bit          m_run;
  logic [31:0] m_cnt;
  logic [14:0] m_mask;
  logic [15:0] m_stat;
  logic [15:0] m_shadow;

  always #2.5 clk = ~clk;

  dtimer_top i_dtimer_top (
    .clk(clk), .rst(rst), .tick_i(tick_i), .evt_i(evt_i),
    .wr_en_i(wr_en_i), .rd_en_i(rd_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string rd_tag(input logic [2:0] a);
    case (a)
      3'd0: return "R3 control read";
      3'd1: return "R2 count low read";
      3'd2: return "R10 count high read";
      3'd3: return "R6 mask read";
      3'd4: return "R7 status read";
      default: return "R12 hole read";
    endcase
  endfunction

  task automatic step(input bit tk, input logic [15:0] ev, input bit we, input bit re,
                      input logic [2:0] ad, input logic [15:0] wd);
    bit          n_run, uf, wcnt;
    logic [31:0] n_cnt;
    logic [14:0] n_mask;
    logic [15:0] n_stat, n_shadow, exp_rd, ctrl;
    @(negedge clk);
    tick_i = tk; evt_i = ev; wr_en_i = we; rd_en_i = re; addr_i = ad; wdata_i = wd;
    n_run = m_run;
    if (we && ad == 3'd0) begin
      if (wd[5]) n_run = 1;
      else if (wd[4]) n_run = 0;
    end
    wcnt = we && (ad == 3'd1 || ad == 3'd2);
    uf = m_run && tk && (m_cnt == 0) && !wcnt;
    n_cnt = m_cnt;
    if (wcnt) begin
      if (ad == 3'd1) n_cnt[15:0] = wd; else n_cnt[31:16] = wd;
    end else if (m_run && tk) n_cnt = (m_cnt == 0) ? 32'hFFFF_FFFF : m_cnt - 1;
    n_mask = (we && ad == 3'd3) ? wd[14:0] : m_mask;
    n_stat = m_stat;
    if (we && ad == 3'd4) n_stat = n_stat & ~wd;
    n_stat = n_stat | ev | (uf ? 16'h0080 : 16'h0);
    ctrl = m_run ? 16'h0020 : 16'h0010;
    case (ad)
      3'd0: exp_rd = ctrl;
      3'd1: exp_rd = m_cnt[15:0];
      3'd2: exp_rd = m_shadow;
      3'd3: exp_rd = {1'b0, m_mask};
      3'd4: exp_rd = m_stat;
      default: exp_rd = 16'h0;
    endcase
    n_shadow = (re && ad == 3'd1) ? m_cnt[31:16] : m_shadow;
    @(posedge clk);
    #1;
    m_run = n_run; m_cnt = n_cnt; m_mask = n_mask; m_stat = n_stat; m_shadow = n_shadow;
    chk(irq_o, |({1'b0, m_mask} & m_stat), "R9 irq level");
    if (re) chk(rdata_o, exp_rd, rd_tag(ad));
  endtask

  task automatic wr(input logic [2:0] ad, input logic [15:0] wd, input bit tk = 0,
                    input logic [15:0] ev = 16'h0);
    step(tk, ev, 1, 0, ad, wd);
  endtask

  task automatic rd(input logic [2:0] ad);
    step(0, 16'h0, 0, 1, ad, 16'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R2 watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1357_2468));
    m_run = 0; m_cnt = 0; m_mask = 0; m_stat = 0; m_shadow = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1 reset state
    chk(irq_o, 0, "R1 irq after reset");
    rd(3'd0); chk(rdata_o, 16'h0010, "R1 control after reset");
    rd(3'd1); chk(rdata_o, 16'h0000, "R1 count low after reset");
    rd(3'd2); chk(rdata_o, 16'h0000, "R1 count high after reset");
    rd(3'd3); chk(rdata_o, 16'h0000, "R1 mask after reset");
    rd(3'd4); chk(rdata_o, 16'h0000, "R1 status after reset");

    // R3 stopped ignores ticks
    wr(3'd1, 16'h0002);
    step(1, 0, 0, 0, 0, 0);
    rd(3'd1); chk(rdata_o, 16'h0002, "R3 ticks ignored when stopped");

    // R2/R4 run through zero
    wr(3'd0, 16'h0020);
    step(1, 0, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0, 0);
    rd(3'd1); chk(rdata_o, 16'h0000, "R2 counted down to zero");
    step(1, 0, 0, 0, 0, 0);
    rd(3'd4); chk(rdata_o, 16'h0080, "R4 timer-complete set");
    rd(3'd1); chk(rdata_o, 16'hFFFF, "R4 low reloaded");
    rd(3'd2); chk(rdata_o, 16'hFFFF, "R10 high captured after reload");

    // R3 stop freezes
    wr(3'd0, 16'h0010);
    step(1, 0, 0, 0, 0, 0);
    rd(3'd1); chk(rdata_o, 16'hFFFF, "R3 frozen after stop");

    // R6 mask top bit, R9 irq
    wr(3'd3, 16'hFFFF);
    rd(3'd3); chk(rdata_o, 16'h7FFF, "R6 mask bit 15 dropped");
    chk(irq_o, 1, "R9 irq raised by masked status");

    // R7 write-one-to-clear
    wr(3'd4, 16'h0000);
    rd(3'd4); chk(rdata_o, 16'h0080, "R7 zero write keeps bits");
    wr(3'd4, 16'h0080);
    chk(irq_o, 0, "R7 cleared bit drops irq");

    // R11 unmaskable top bit
    step(0, 16'h8000, 0, 0, 0, 0);
    chk(irq_o, 0, "R11 bit 15 gives no irq");
    rd(3'd4); chk(rdata_o, 16'h8000, "R11 event sets bit 15");

    // R8 set beats clear
    step(0, 16'h0008, 0, 0, 0, 0);
    wr(3'd4, 16'h0008, 0, 16'h0008);
    rd(3'd4); chk(rdata_o, 16'h8008, "R8 set wins over clear");

    // R3 both bits: start wins
    wr(3'd0, 16'h0030);
    rd(3'd0); chk(rdata_o, 16'h0020, "R3 start wins over stop");

    // R5 count writes beat ticks
    wr(3'd1, 16'h0005, 1);
    wr(3'd2, 16'h0000, 1);
    rd(3'd1); chk(rdata_o, 16'h0005, "R5 write beats tick");
    step(1, 0, 0, 0, 0, 0);
    rd(3'd1); chk(rdata_o, 16'h0004, "R5 counting resumes from write");

    // R12 hole write has no effect
    wr(3'd6, 16'hFFFF);
    rd(3'd6); chk(rdata_o, 16'h0000, "R12 hole reads zero");
    rd(3'd4); chk(rdata_o, 16'h8008, "R12 hole write left status");

    // random phase
    for (int i = 0; i < 3000; i++) begin
      bit          tk;
      logic [15:0] ev, wd;
      int          op;
      tk = ($urandom % 2) == 0;
      ev = (($urandom % 12) == 0) ? (16'h1 << ($urandom % 16)) : 16'h0;
      op = $urandom % 10;
      case (op)
        0: step(tk, ev, 1, 0, 3'd0, (($urandom % 2) ? 16'h0020 : 16'h0) | (($urandom % 3 == 0) ? 16'h0010 : 16'h0));
        1: step(tk, ev, 1, 0, 3'd1, 16'($urandom % 6));
        2: step(tk, ev, 1, 0, 3'd2, ($urandom % 4 == 0) ? 16'($urandom) : 16'h0);
        3: step(tk, ev, 1, 0, 3'd3, 16'($urandom));
        4: step(tk, ev, 1, 0, 3'd4, 16'($urandom));
        5: step(tk, ev, 1, 0, 3'(5 + $urandom % 3), 16'($urandom));
        default: begin
          wd = 16'($urandom);
          step(tk, ev, 0, 1, 3'($urandom % 8), wd);
        end
      endcase
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule